// File: doc/BRIEF.md
# Counter-array timebase

This block is the shared 16-bit up-counter that feeds a bank of capture/compare channels in a small microcontroller. The counter advances by one on each pulse of a chosen count source. A two-bit source field picks one of four sources: a slow internal tick, a fast internal tick, the overflow pulse of a neighbouring timer, or a rising edge seen on an external pin. The pin is synchronised to the oscillator clock and its edge rate is capped. A double-speed input halves both internal tick periods.

Counting needs the run input to be high. A gate bit in the mode register can also freeze the counter while the core is idle. When the count wraps, a sticky overflow flag is set. That flag raises the interrupt line only if its enable bit is set. The mode register also holds a watchdog-enable bit, which goes out as a level to capture/compare channel 4. Software reaches the mode register, both count bytes and the flag through one small register port.

Top module: `pcat_timebase`

## Requirements
- R1: After reset the mode register reads 0x00, both count bytes read 0x00, and ovf_flag, irq and wdog_en are 0.
- R2: With source field 00 the count rises once every 12 clocks, or once every 6 clocks when x2_mode is 1.
- R3: With source field 01 the count rises once every 4 clocks, or once every 2 clocks when x2_mode is 1.
- R4: With source field 10 the count rises once for each clock cycle in which t0_ovf is high.
- R5: With source field 11 the count rises once per low-to-high transition of ext_pin. The pin is sampled every 4 clocks, so there are never fewer than 8 clocks between two counts.
- R6: When mode bit 7 (idle gate) is 1 and idle is high, the count holds. When bit 7 is 0, idle has no effect on counting.
- R7: While run is low the count holds, except when software writes a count byte.
- R8: A count step from 0xFFFF wraps to 0x0000 and sets ovf_flag. ovf_flag stays set until software clears it. irq is high exactly when ovf_flag and mode bit 0 (overflow interrupt enable) are both 1.
- R9: A write to address 3 loads ovf_flag from wdata bit 0. This write wins over a wrap that happens in the same cycle.
- R10: A write to address 1 (low byte) or address 2 (high byte) loads that byte in the same cycle, and no count step is applied in that cycle.
- R11: Address 0 is the mode register: bit 7 is the idle gate, bit 6 is the watchdog enable (driven on wdog_en), bits 2:1 are the source field, and bit 0 is the interrupt enable. Bits 5:3 ignore writes and read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| x2_mode | input | 1 | Double-speed mode: halves both internal tick periods |
| idle | input | 1 | Core idle indication |
| run | input | 1 | Run control; the counter steps only while this is high |
| t0_ovf | input | 1 | Overflow pulse from the neighbouring timer |
| ext_pin | input | 1 | External count pin, asynchronous to clk |
| wr_en | input | 1 | Register write strobe |
| addr | input | 2 | Register select: 0 mode, 1 count low byte, 2 count high byte, 3 flag |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for the selected register (combinational) |
| ovf_flag | output | 1 | Sticky overflow flag |
| irq | output | 1 | Overflow interrupt request |
| wdog_en | output | 1 | Watchdog enable level for channel 4 |

## Verification
Two pairs of events can fall in the same cycle. The first pair is a wrap from 0xFFFF and a software write that clears the flag. The bench sets the flag with one wrap, reloads 0xFFFF, then drives t0_ovf and the flag-clear write in the same cycle; the flag must read 0 while the count reads 0x0000. The second pair is a count step and a write to a count byte. The bench holds t0_ovf high during a low-byte write and expects exactly the written byte back, not that byte plus one.

// File: rtl/pcat_pkg.sv
package pcat_pkg;
    typedef enum logic [1:0] {
        SRC_SLOW = 2'b00,
        SRC_FAST = 2'b01,
        SRC_TMR  = 2'b10,
        SRC_PIN  = 2'b11
    } src_sel_e;

    localparam logic [1:0] A_MODE = 2'd0;
    localparam logic [1:0] A_LO   = 2'd1;
    localparam logic [1:0] A_HI   = 2'd2;
    localparam logic [1:0] A_FLAG = 2'd3;
endpackage

// File: rtl/pcat_prescale.sv
module pcat_prescale
    import pcat_pkg::*;
#(
    parameter int DIV_SLOW = 12,
    parameter int DIV_FAST = 4,
    localparam int CW = $clog2(DIV_SLOW)
) (
    input  logic     clk,
    input  logic     rst_n,
    input  src_sel_e sel,
    input  logic     x2,
    output logic     tick
);
    typedef struct packed {
        logic [CW-1:0] cnt;
        src_sel_e      sel_prev;
        logic          x2_prev;
    } pre_t;

    pre_t s_d, s_q;
    logic [CW-1:0] lim;
    logic          changed;

    always_comb begin
        int div;
        div = (sel == SRC_SLOW) ? DIV_SLOW : DIV_FAST;
        if (x2) div = div / 2;
        lim     = CW'(div - 1);
        changed = (sel != s_q.sel_prev) || (x2 != s_q.x2_prev);
        tick    = !changed && (s_q.cnt == lim);

        s_d          = s_q;
        s_d.sel_prev = sel;
        s_d.x2_prev  = x2;
        if (changed || s_q.cnt >= lim) s_d.cnt = '0;
        else                            s_d.cnt = s_q.cnt + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '{cnt: '0, sel_prev: SRC_SLOW, x2_prev: 1'b0};
        else        s_q <= s_d;
    end
endmodule

// File: rtl/pcat_pinsync.sv
module pcat_pinsync #(
    parameter int SAMPLE_GAP = 4,
    localparam int PW = (SAMPLE_GAP > 1) ? $clog2(SAMPLE_GAP) : 1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin,
    output logic pulse
);
    typedef struct packed {
        logic          s1;
        logic          s2;
        logic [PW-1:0] phase;
        logic          samp;
        logic          pulse;
    } sync_t;

    sync_t s_d, s_q;

    always_comb begin
        s_d       = s_q;
        s_d.s1    = pin;
        s_d.s2    = s_q.s1;
        s_d.pulse = 1'b0;
        if (s_q.phase == PW'(SAMPLE_GAP - 1)) begin
            s_d.phase = '0;
            s_d.samp  = s_q.s2;
            s_d.pulse = !s_q.samp && s_q.s2;
        end else begin
            s_d.phase = s_q.phase + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign pulse = s_q.pulse;
endmodule

// File: rtl/pcat_timebase.sv
module pcat_timebase
    import pcat_pkg::*;
#(
    parameter int DIV_SLOW   = 12,
    parameter int DIV_FAST   = 4,
    parameter int SAMPLE_GAP = 4,
    localparam int CNT_W     = 16
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       x2_mode,
    input  logic       idle,
    input  logic       run,
    input  logic       t0_ovf,
    input  logic       ext_pin,
    input  logic       wr_en,
    input  logic [1:0] addr,
    input  logic [7:0] wdata,
    output logic [7:0] rdata,
    output logic       ovf_flag,
    output logic       irq,
    output logic       wdog_en
);
    typedef struct packed {
        logic             idle_gate;
        logic             wdog;
        src_sel_e         sel;
        logic             ovf_ie;
        logic [CNT_W-1:0] count;
        logic             flag;
    } tb_state_t;

    tb_state_t s_d, s_q;
    logic pre_tick, pin_pulse, src_tick, inc, cnt_wr, flag_wr, wrap;
    logic [CNT_W-1:0] cnt_now;
    logic idle_gate_now;

    pcat_prescale #(.DIV_SLOW(DIV_SLOW), .DIV_FAST(DIV_FAST)) u_pre (
        .clk  (clk),
        .rst_n(rst_n),
        .sel  (s_q.sel),
        .x2   (x2_mode),
        .tick (pre_tick)
    );

    pcat_pinsync #(.SAMPLE_GAP(SAMPLE_GAP)) u_pin (
        .clk  (clk),
        .rst_n(rst_n),
        .pin  (ext_pin),
        .pulse(pin_pulse)
    );

    always_comb begin
        case (s_q.sel)
            SRC_SLOW, SRC_FAST: src_tick = pre_tick;
            SRC_TMR:            src_tick = t0_ovf;
            default:            src_tick = pin_pulse;
        endcase
        inc     = run && src_tick && !(s_q.idle_gate && idle);
        cnt_wr  = wr_en && (addr == A_LO || addr == A_HI);
        flag_wr = wr_en && (addr == A_FLAG);
        wrap    = inc && !cnt_wr && (s_q.count == '1);

        s_d = s_q;
        if (wr_en) begin
            case (addr)
                A_MODE: begin
                    s_d.idle_gate = wdata[7];
                    s_d.wdog      = wdata[6];
                    s_d.sel       = src_sel_e'(wdata[2:1]);
                    s_d.ovf_ie    = wdata[0];
                end
                A_LO:    s_d.count[7:0]  = wdata;
                A_HI:    s_d.count[15:8] = wdata;
                default: s_d.flag        = wdata[0];
            endcase
        end
        if (inc && !cnt_wr) s_d.count = s_q.count + 1'b1;
        if (wrap && !flag_wr) s_d.flag = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '{idle_gate: 1'b0, wdog: 1'b0, sel: SRC_SLOW,
                              ovf_ie: 1'b0, count: '0, flag: 1'b0};
        else        s_q <= s_d;
    end

    always_comb begin
        case (addr)
            A_MODE:  rdata = {s_q.idle_gate, s_q.wdog, 3'b000, s_q.sel, s_q.ovf_ie};
            A_LO:    rdata = s_q.count[7:0];
            A_HI:    rdata = s_q.count[15:8];
            default: rdata = {7'b0, s_q.flag};
        endcase
    end

    assign ovf_flag      = s_q.flag;
    assign irq           = s_q.flag && s_q.ovf_ie;
    assign wdog_en       = s_q.wdog;
    assign cnt_now       = s_q.count;
    assign idle_gate_now = s_q.idle_gate;
endmodule

// File: rtl/pcat_timebase_chk.sv
module pcat_timebase_chk #(
    parameter int SAMPLE_GAP = 4
) (
    input logic        clk,
    input logic        rst_n,
    input logic        idle,
    input logic        run,
    input logic        wr_en,
    input logic [1:0]  addr,
    input logic [7:0]  wdata,
    input logic [7:0]  rdata,
    input logic        ovf_flag,
    input logic        irq,
    input logic [15:0] cnt,
    input logic        pin_pulse,
    input logic        idle_gate
);
    logic [3:0] gap_q;
    logic       cnt_wr;

    assign cnt_wr = wr_en && (addr == 2'd1 || addr == 2'd2);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)          gap_q <= 4'hF;
        else if (pin_pulse)  gap_q <= 4'h0;
        else if (gap_q != 4'hF) gap_q <= gap_q + 1'b1;
    end

    p_pin_gap_r5: assert property (@(posedge clk) disable iff (!rst_n)
        pin_pulse |-> gap_q >= 4'(2 * SAMPLE_GAP - 1));

    p_idle_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (idle_gate && idle && !cnt_wr) |=> $stable(cnt));

    p_run_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!run && !cnt_wr) |=> $stable(cnt));

    p_flag_from_wrap_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ovf_flag) |-> ($past(cnt) == 16'hFFFF || $past(wr_en && addr == 2'd3)));

    p_irq_needs_flag_r8: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> ovf_flag);

    p_flag_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == 2'd3 && !wdata[0]) |=> !ovf_flag);

    p_low_write_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == 2'd1) |=> cnt[7:0] == $past(wdata));

    p_reserved_zero_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (addr == 2'd0) |-> rdata[5:3] == 3'b000);
endmodule

bind pcat_timebase pcat_timebase_chk #(.SAMPLE_GAP(SAMPLE_GAP)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .idle     (idle),
    .run      (run),
    .wr_en    (wr_en),
    .addr     (addr),
    .wdata    (wdata),
    .rdata    (rdata),
    .ovf_flag (ovf_flag),
    .irq      (irq),
    .cnt      (cnt_now),
    .pin_pulse(pin_pulse),
    .idle_gate(idle_gate_now)
);

// File: tb/sim_pcat_timebase.sv
`timescale 1ns/1ps
module sim_pcat_timebase;
    logic       clk = 1'b0, rst_n = 1'b0;
    logic       x2_mode = 1'b0, idle = 1'b0, run = 1'b0, t0_ovf = 1'b0, ext_pin = 1'b0;
    logic       wr_en = 1'b0;
    logic [1:0] addr = 2'd0;
    logic [7:0] wdata = 8'd0;
    logic [7:0] rdata;
    logic       ovf_flag, irq, wdog_en;
    int         n_run = 0, n_fail = 0;

    always #2.5 clk = ~clk;

    pcat_timebase u0 (
        .clk(clk), .rst_n(rst_n), .x2_mode(x2_mode), .idle(idle), .run(run),
        .t0_ovf(t0_ovf), .ext_pin(ext_pin), .wr_en(wr_en), .addr(addr),
        .wdata(wdata), .rdata(rdata), .ovf_flag(ovf_flag), .irq(irq), .wdog_en(wdog_en)
    );

    typedef struct packed {
        logic [1:0] sel;
        logic       x2;
        logic [7:0] win;
        logic [7:0] expct;
    } vec_t;

    localparam vec_t VECS [8] = '{
        '{2'b00, 1'b0, 8'd120, 8'd10},
        '{2'b00, 1'b1, 8'd60,  8'd10},
        '{2'b00, 1'b0, 8'd36,  8'd3},
        '{2'b00, 1'b1, 8'd6,   8'd1},
        '{2'b01, 1'b0, 8'd40,  8'd10},
        '{2'b01, 1'b1, 8'd20,  8'd10},
        '{2'b01, 1'b0, 8'd4,   8'd1},
        '{2'b01, 1'b1, 8'd2,   8'd1}
    };

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [7:0] d);
        addr = a;
        #1;
        d = rdata;
    endtask

    task automatic rd_cnt(output logic [15:0] c);
        logic [7:0] lo, hi;
        rd(2'd1, lo);
        rd(2'd2, hi);
        c = {hi, lo};
    endtask

    task automatic window(input int cycles);
        @(negedge clk);
        run = 1'b1;
        repeat (cycles) @(negedge clk);
        run = 1'b0;
    endtask

    task automatic zero_cnt();
        wr(2'd1, 8'h00);
        wr(2'd2, 8'h00);
    endtask

    task automatic finish_up();
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_run++;
        n_fail++;
        $display("FAIL watchdog R1 actual=hung expected=done");
        finish_up();
    end

    initial begin
        logic [7:0]  b;
        logic [15:0] c;
        repeat (3) @(negedge clk);
        // R1: reset state
        rd(2'd0, b);  chk("R1 mode", {8'h0, b}, 16'h0000);
        rd_cnt(c);    chk("R1 count", c, 16'h0000);
        chk("R1 flags", {13'h0, ovf_flag, irq, wdog_en}, 16'h0000);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // R2, R3: table of internal prescaled sources
        foreach (VECS[i]) begin
            x2_mode = VECS[i].x2;
            wr(2'd0, {5'b0, VECS[i].sel, 1'b0});
            repeat (20) @(negedge clk);
            zero_cnt();
            window(int'(VECS[i].win));
            rd_cnt(c);
            chk(VECS[i].sel == 2'b00 ? "R2 slow tick" : "R3 fast tick", c, {8'h0, VECS[i].expct});
        end
        x2_mode = 1'b0;

        // R7: run low holds the count
        wr(2'd0, 8'h02);
        zero_cnt();
        repeat (40) @(negedge clk);
        rd_cnt(c); chk("R7 run gate", c, 16'h0000);

        // R6: idle gate set and idle high
        wr(2'd0, 8'h82);
        idle = 1'b1;
        repeat (10) @(negedge clk);
        window(40);
        rd_cnt(c); chk("R6 idle frozen", c, 16'h0000);
        wr(2'd0, 8'h02);
        repeat (10) @(negedge clk);
        window(40);
        rd_cnt(c); chk("R6 idle ignored", c, 16'd10);
        idle = 1'b0;

        // R4: neighbouring timer pulses
        wr(2'd0, 8'h04);
        zero_cnt();
        @(negedge clk); run = 1'b1;
        for (int k = 0; k < 7; k++) begin
            t0_ovf = 1'b1; @(negedge clk);
            t0_ovf = 1'b0; repeat (3) @(negedge clk);
        end
        t0_ovf = 1'b1; repeat (3) @(negedge clk); t0_ovf = 1'b0;
        run = 1'b0;
        rd_cnt(c); chk("R4 timer pulses", c, 16'd10);

        // R5: slow external pin edges
        wr(2'd0, 8'h06);
        ext_pin = 1'b0;
        repeat (20) @(negedge clk);
        zero_cnt();
        @(negedge clk); run = 1'b1;
        for (int k = 0; k < 5; k++) begin
            ext_pin = 1'b1; repeat (8) @(negedge clk);
            ext_pin = 1'b0; repeat (8) @(negedge clk);
        end
        repeat (20) @(negedge clk);
        run = 1'b0;
        rd_cnt(c); chk("R5 pin edges", c, 16'd5);

        // R5: fast pin toggling is rate limited to one count per 8 clocks
        zero_cnt();
        @(negedge clk); run = 1'b1;
        for (int k = 0; k < 16; k++) begin
            ext_pin = 1'b1; repeat (3) @(negedge clk);
            ext_pin = 1'b0; repeat (3) @(negedge clk);
        end
        run = 1'b0;
        repeat (12) @(negedge clk);
        rd_cnt(c); chk("R5 rate cap", {15'h0, (c <= 16'd12)}, 16'h0001);
        n_run++;
        if (c == 16'd0) begin
            n_fail++;
            $display("FAIL R5 fast pin no counts actual=%h expected=nonzero", c);
        end

        // R8: wrap, sticky flag, interrupt enable
        wr(2'd0, 8'h04);
        wr(2'd1, 8'hFF); wr(2'd2, 8'hFF);
        @(negedge clk); run = 1'b1;
        t0_ovf = 1'b1; @(negedge clk); t0_ovf = 1'b0;
        repeat (5) @(negedge clk);
        rd_cnt(c); chk("R8 wrap count", c, 16'h0000);
        chk("R8 flag set irq masked", {14'h0, ovf_flag, irq}, 16'h0002);
        wr(2'd0, 8'h05);
        chk("R8 irq enabled", {15'h0, irq}, 16'h0001);

        // R9: clearing write wins over a same-cycle wrap
        wr(2'd1, 8'hFF); wr(2'd2, 8'hFF);
        @(negedge clk);
        t0_ovf = 1'b1; wr_en = 1'b1; addr = 2'd3; wdata = 8'h00;
        @(negedge clk);
        t0_ovf = 1'b0; wr_en = 1'b0;
        rd_cnt(c); chk("R9 wrap count", c, 16'h0000);
        chk("R9 write wins", {14'h0, ovf_flag, irq}, 16'h0000);

        // R10: count byte write suppresses same-cycle step
        wr(2'd1, 8'h10); wr(2'd2, 8'h00);
        @(negedge clk);
        t0_ovf = 1'b1; wr_en = 1'b1; addr = 2'd1; wdata = 8'h55;
        @(negedge clk);
        t0_ovf = 1'b0; wr_en = 1'b0;
        run = 1'b0;
        rd_cnt(c); chk("R10 write suppresses step", c, 16'h0055);

        // R11: field layout, reserved bits, watchdog level
        wr(2'd0, 8'h78);
        rd(2'd0, b); chk("R11 reserved read zero", {8'h0, b}, 16'h0040);
        chk("R11 watchdog out", {15'h0, wdog_en}, 16'h0001);
        wr(2'd0, 8'hC7);
        rd(2'd0, b); chk("R11 full mode", {8'h0, b}, 16'h00C7);

        finish_up();
    end
endmodule